// File: doc/BRIEF.md
# Encoded-Function Integer ALU

A purely combinational integer arithmetic and logic unit for a small 32-bit scalar core. Two operands and a 4-bit function code go in; a 32-bit result and an invalid-code flag come out in the same cycle. The function code follows a fixed project-specific numbering rather than the instruction encoding fields, so the decoder upstream translates each instruction into one of twelve codes before the ALU sees it.

The twelve codes cover a no-operation that returns zero, a pass-through of the first operand, bitwise logic, wrapping add and subtract, signed and unsigned less-than, and three shifts (left, logical right, arithmetic right). One shared adder serves add, subtract and both comparisons. Codes 12 to 15 are unassigned; they return zero and raise the invalid flag so the surrounding pipeline can trap.

Top module: `alu_core`

## Requirements
- R1: Function code 0 (no-op) drives result_o to zero for any operands.
- R2: Function code 1 drives result_o to op_a_i XOR op_b_i.
- R3: Function code 2 (copy) drives result_o to op_a_i unchanged, ignoring op_b_i.
- R4: Function code 3 drives result_o to 1 when op_a_i is below op_b_i as unsigned numbers, else 0; bits 31..1 are always zero.
- R5: Function code 4 drives result_o to op_a_i AND op_b_i; function code 11 drives it to op_a_i OR op_b_i.
- R6: Function code 5 drives result_o to op_a_i plus op_b_i modulo 2^32.
- R7: Function code 8 drives result_o to op_a_i minus op_b_i modulo 2^32.
- R8: Function code 6 drives result_o to 1 when op_a_i is below op_b_i as two's-complement numbers, else 0; bits 31..1 are always zero.
- R9: Function code 7 shifts op_a_i right filling with its bit 31; function code 9 shifts it right filling with zeros.
- R10: Function code 10 shifts op_a_i left filling with zeros.
- R11: Every shift uses only op_b_i[4:0] as the shift amount; bits 31..5 of op_b_i have no effect.
- R12: For function codes 12 to 15 result_o is zero and invalid_o is 1; for codes 0 to 11 invalid_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | 32 | First operand; value shifted, copied or minuend |
| op_b_i | input | 32 | Second operand; low five bits are the shift amount |
| func_i | input | 4 | Operation code, 0 to 11 valid |
| result_o | output | 32 | Operation result |
| invalid_o | output | 1 | High when func_i is outside 0 to 11 |

## Verification
The checks are immediate and evaluate the settled combinational outputs, so they assume the operands and code are stable two-state values whenever they are sampled. The bench honours this by changing inputs only just after a clock rise and comparing only at the following fall, never leaving any input undriven. Stimulus mixes directed corners (sign boundaries, shift by 0 and 31, shift operands with high bits set, wrap-around sums) with a long run of pseudo-random operands across all sixteen codes, including the unassigned ones.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned FN_COUNT = 12;

  typedef enum logic [CODE_W-1:0] {
    FN_NOP  = 4'd0,
    FN_XOR  = 4'd1,
    FN_COPY = 4'd2,
    FN_SLTU = 4'd3,
    FN_AND  = 4'd4,
    FN_ADD  = 4'd5,
    FN_SLT  = 4'd6,
    FN_SRA  = 4'd7,
    FN_SUB  = 4'd8,
    FN_SRL  = 4'd9,
    FN_SLL  = 4'd10,
    FN_OR   = 4'd11
  } alu_fn_e;

  typedef enum logic [1:0] {
    LG_XOR  = 2'd0,
    LG_AND  = 2'd1,
    LG_OR   = 2'd2,
    LG_COPY = 2'd3
  } logic_sel_e;
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic_sel_e        sel_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    unique case (sel_i)
      LG_XOR:  y_o = a_i ^ b_i;
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              lt_u_o,
  output logic              lt_s_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   full;

  // single adder; subtract as a + ~b + 1
  assign b_eff = sub_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
  assign sum_o = full[DATA_W-1:0];

  // valid only while sub_i is set: no carry out means a borrow
  assign lt_u_o = ~full[DATA_W];
  assign lt_s_o = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : full[MSB];
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]         a_i,
  input  logic [$clog2(DATA_W)-1:0] amt_i,
  input  logic                      left_i,
  input  logic                      arith_i,
  output logic [DATA_W-1:0]         y_o
);
  localparam int unsigned STAGES = $clog2(DATA_W);

  logic [DATA_W-1:0] src_rev;
  logic [DATA_W-1:0] stage [0:STAGES];
  logic [DATA_W-1:0] res_rev;
  logic              fill;

  // left shift = reverse, shift right, reverse
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign src_rev[i] = a_i[DATA_W-1-i];
    assign res_rev[i] = stage[STAGES][DATA_W-1-i];
  end

  assign fill     = arith_i & ~left_i & a_i[DATA_W-1];
  assign stage[0] = left_i ? src_rev : a_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int unsigned DIST = 1 << k;
    assign stage[k+1] = amt_i[k]
      ? {{DIST{fill}}, stage[k][DATA_W-1:DIST]}
      : stage[k];
  end

  assign y_o = left_i ? res_rev : stage[STAGES];
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [CODE_W-1:0] func_i,
  output logic [DATA_W-1:0] result_o,
  output logic              invalid_o
);
  localparam int unsigned SH_W = $clog2(DATA_W);

  alu_fn_e           fn;
  logic              code_ok;
  logic_sel_e        lg_sel;
  logic              use_sub;
  logic              sh_left;
  logic              sh_arith;
  logic [DATA_W-1:0] lg_y;
  logic [DATA_W-1:0] as_y;
  logic [DATA_W-1:0] sh_y;
  logic              lt_u;
  logic              lt_s;

  assign fn      = alu_fn_e'(func_i);
  assign code_ok = (func_i < CODE_W'(FN_COUNT));

  always_comb begin
    lg_sel = LG_COPY;
    unique case (fn)
      FN_XOR:  lg_sel = LG_XOR;
      FN_AND:  lg_sel = LG_AND;
      FN_OR:   lg_sel = LG_OR;
      default: lg_sel = LG_COPY;
    endcase
  end

  assign use_sub  = (fn == FN_SUB) || (fn == FN_SLT) || (fn == FN_SLTU);
  assign sh_left  = (fn == FN_SLL);
  assign sh_arith = (fn == FN_SRA);

  alu_logic_unit #(.DATA_W(DATA_W)) u_logic (
    .a_i   (op_a_i),
    .b_i   (op_b_i),
    .sel_i (lg_sel),
    .y_o   (lg_y)
  );

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .sub_i  (use_sub),
    .sum_o  (as_y),
    .lt_u_o (lt_u),
    .lt_s_o (lt_s)
  );

  alu_shifter #(.DATA_W(DATA_W)) u_shift (
    .a_i     (op_a_i),
    .amt_i   (op_b_i[SH_W-1:0]),
    .left_i  (sh_left),
    .arith_i (sh_arith),
    .y_o     (sh_y)
  );

  always_comb begin
    result_o = '0;
    if (code_ok) begin
      unique case (fn)
        FN_XOR, FN_AND, FN_OR, FN_COPY: result_o = lg_y;
        FN_ADD, FN_SUB:                 result_o = as_y;
        FN_SLTU:                        result_o = {{(DATA_W-1){1'b0}}, lt_u};
        FN_SLT:                         result_o = {{(DATA_W-1){1'b0}}, lt_s};
        FN_SRA, FN_SRL, FN_SLL:         result_o = sh_y;
        default:                        result_o = '0;
      endcase
    end
  end

  assign invalid_o = ~code_ok;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic [DATA_W-1:0] op_a_i,
  input logic [DATA_W-1:0] op_b_i,
  input logic [3:0]        func_i,
  input logic [DATA_W-1:0] result_o,
  input logic              invalid_o
);
  localparam int unsigned SH_W = $clog2(DATA_W);

  always_comb begin
    assert_nop_zero_R1: assert (func_i != 4'd0 || result_o == '0);
    assert_copy_pass_R3: assert (func_i != 4'd2 || result_o == op_a_i);
    assert_sltu_bool_R4: assert (func_i != 4'd3 || result_o[DATA_W-1:1] == '0);
    assert_slt_bool_R8: assert (func_i != 4'd6 || result_o[DATA_W-1:1] == '0);
    assert_sra_sign_R9: assert (func_i != 4'd7 || op_b_i[SH_W-1:0] == '0
                                || result_o[DATA_W-1] == op_a_i[DATA_W-1]);
    assert_srl_zero_R9: assert (func_i != 4'd9 || op_b_i[SH_W-1:0] == '0
                                || result_o[DATA_W-1] == 1'b0);
    assert_sll_zero_R10: assert (func_i != 4'd10 || op_b_i[SH_W-1:0] == '0
                                 || result_o[0] == 1'b0);
    assert_invalid_flag_R12: assert (invalid_o == (func_i > 4'd11));
    assert_invalid_zero_R12: assert (!invalid_o || result_o == '0);
  end
endmodule

bind alu_core alu_core_chk #(.DATA_W(DATA_W)) u_chk (
  .op_a_i    (op_a_i),
  .op_b_i    (op_b_i),
  .func_i    (func_i),
  .result_o  (result_o),
  .invalid_o (invalid_o)
);

// File: tb/sim_alu_core.sv
`timescale 1ns/1ps
module sim_alu_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [3:0]  func = '0;
  logic [31:0] result;
  logic        invalid;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  alu_core u0 (
    .op_a_i    (op_a),
    .op_b_i    (op_b),
    .func_i    (func),
    .result_o  (result),
    .invalid_o (invalid)
  );

  function automatic logic [31:0] model(int code, logic [31:0] a, logic [31:0] b);
    int sh;
    logic [31:0] r;
    sh = int'(b & 32'd31);
    case (code)
      1:  r = a ^ b;
      2:  r = a;
      3:  r = (a < b) ? 32'd1 : 32'd0;
      4:  r = a & b;
      5:  r = a + b;
      6:  r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      7:  r = $signed(a) >>> sh;
      8:  r = a - b;
      9:  r = a >> sh;
      10: r = a << sh;
      11: r = a | b;
      default: r = 32'd0;
    endcase
    return r;
  endfunction

  function automatic string req_of(int code);
    case (code)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 11: return "R5";
      5: return "R6";
      6: return "R8";
      7, 9: return "R9";
      8: return "R7";
      10: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(int code, logic [31:0] a, logic [31:0] b, string tag);
    logic [31:0] exp_r;
    logic        exp_inv;
    @(posedge clk);
    op_a = a;
    op_b = b;
    func = code[3:0];
    exp_r   = model(code, a, b);
    exp_inv = (code > 11);
    @(negedge clk);
    vectors++;
    if (result !== exp_r) begin
      fails++;
      $display("FAIL %s code=%0d a=%h b=%h result got %h exp %h", tag, code, a, b, result, exp_r);
    end
    if (invalid !== exp_inv) begin
      fails++;
      $display("FAIL R12 code=%0d invalid got %b exp %b", code, invalid, exp_inv);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: all-zero inputs give zero, not invalid (R1)
    apply(0, 32'h0, 32'h0, "R1");
    apply(0, 32'hFFFF_FFFF, 32'h1234_5678, "R1");
    apply(1, 32'hF0F0_F0F0, 32'hFF00_FF00, "R2");
    apply(2, 32'hDEAD_BEEF, 32'h0, "R3");
    apply(2, 32'hDEAD_BEEF, 32'hFFFF_FFFF, "R3");
    apply(3, 32'h0000_0001, 32'hFFFF_FFFF, "R4");
    apply(3, 32'hFFFF_FFFF, 32'h0000_0001, "R4");
    apply(3, 32'h5, 32'h5, "R4");
    apply(4, 32'hAAAA_5555, 32'h0FF0_F00F, "R5");
    apply(11, 32'hAAAA_5555, 32'h0FF0_F00F, "R5");
    apply(5, 32'hFFFF_FFFF, 32'h1, "R6");
    apply(5, 32'h7FFF_FFFF, 32'h1, "R6");
    apply(8, 32'h0, 32'h1, "R7");
    apply(8, 32'h8000_0000, 32'h1, "R7");
    apply(6, 32'hFFFF_FFFF, 32'h1, "R8");
    apply(6, 32'h8000_0000, 32'h7FFF_FFFF, "R8");
    apply(6, 32'h7FFF_FFFF, 32'h8000_0000, "R8");
    apply(6, 32'h3, 32'h3, "R8");
    apply(7, 32'h8000_0000, 32'd31, "R9");
    apply(7, 32'h8765_4321, 32'd4, "R9");
    apply(9, 32'h8765_4321, 32'd4, "R9");
    apply(9, 32'h8000_0000, 32'd31, "R9");
    apply(7, 32'h8765_4321, 32'd0, "R9");
    apply(10, 32'h8765_4321, 32'd4, "R10");
    apply(10, 32'h0000_0001, 32'd31, "R10");
    apply(10, 32'h1234_5678, 32'd0, "R10");
    // high bits of the shift operand ignored
    apply(10, 32'h0000_0003, 32'hFFFF_FFE1, "R11");
    apply(9, 32'hF000_0000, 32'h0000_0024, "R11");
    apply(7, 32'hF000_0000, 32'h8000_0020, "R11");
    for (int c = 12; c < 16; c++) apply(c, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R12");
    for (int i = 0; i < 3000; i++) begin
      int c;
      c = int'($urandom_range(15, 0));
      apply(c, $urandom, $urandom, req_of(c));
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule